// File: doc/BRIEF.md
# Wiper Position Register with Prioritised Load Paths

This block holds the position of one digitally controlled potentiometer wiper as a small unsigned register and turns that position into a one-hot vector that closes exactly one tap switch of the resistor string. The position can change in four ways. A recall strobe copies the stored power-on setting (non-volatile slot zero) into the register. A host write strobe loads a byte supplied over the serial bus. A copy strobe loads the contents of whichever stored slot the command selected. In step mode, a step pulse moves the wiper one tap up or down.

Step mode is entered by the bus controller after it accepts an increment/decrement command, and it stays active until a stop condition. While it is active, every high phase of the serial clock produces one step pulse, and the level of the data line gives the direction. When several sources fire in the same cycle, a fixed priority decides which one wins. Steps saturate at both ends of the string. The tap vector is registered, so it follows the position one cycle later. Position 0 selects the low terminal and the all-ones position selects the high terminal.

Top module: `wiper_pos_reg`

## Requirements
- R1: After reset the position reads 0 and the tap vector has only bit 0 set.
- R2: A cycle with `recall_i` high loads `recall_val_i` into the position, visible after the next clock edge.
- R3: A cycle with `host_wr_i` high and no recall loads `host_val_i` into the position.
- R4: A cycle with `copy_wr_i` high and neither recall nor host write loads `copy_val_i` into the position.
- R5: When sources coincide, the winner is chosen in this order: recall, then host write, then copy, then step.
- R6: A step (`step_mode_i` and `step_pulse_i` high, no load strobe) with `step_up_i` = 1 raises the position by exactly one.
- R7: A step with `step_up_i` = 0 lowers the position by exactly one.
- R8: Stepping saturates: an up step at the all-ones position and a down step at 0 leave the position unchanged.
- R9: Step pulses while `step_mode_i` is low are ignored, and with no strobe and no step the position holds its value.
- R10: The tap vector always has exactly one bit set, and that bit's index equals the position held one cycle earlier. Bit 0 is the low terminal and bit 2^POS_W-1 is the high terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_i | input | 1 | Power-up recall strobe |
| recall_val_i | input | POS_W | Contents of stored slot zero |
| host_wr_i | input | 1 | Host write strobe |
| host_val_i | input | POS_W | Byte written by the host |
| copy_wr_i | input | 1 | Parallel copy strobe |
| copy_val_i | input | POS_W | Contents of the selected stored slot |
| step_mode_i | input | 1 | Step mode active |
| step_pulse_i | input | 1 | One-cycle pulse per serial clock high phase |
| step_up_i | input | 1 | Step direction: 1 up, 0 down |
| pos_o | output | POS_W | Current wiper position |
| tap_o | output | 2^POS_W | Registered one-hot tap select |

## Verification
The embedded properties check the following on every clock: that the tap vector is one-hot and trails the position by one cycle, that recall and host-write values land, that the position holds when nothing fires, and that saturation and single steps behave. The directed scenarios show what a property cannot see on its own. These are the full priority ladder with all four sources colliding, the reset contents, runs of several steps in both directions, and step pulses arriving outside step mode. The scenarios also confirm the end-terminal encodings at both extremes of the tap vector.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   typedef enum logic [2:0] {
      SRC_NONE   = 3'd0,
      SRC_RECALL = 3'd1,
      SRC_HOST   = 3'd2,
      SRC_COPY   = 3'd3,
      SRC_STEP   = 3'd4
   } load_src_e;
endpackage

// File: rtl/wiper_step_unit.sv
module wiper_step_unit #(
   parameter int POS_W = 8
) (
   input  logic [POS_W-1:0] cur_i,
   input  logic             up_i,
   output logic [POS_W-1:0] nxt_o
);
   localparam logic [POS_W-1:0] TOP_POS = {POS_W{1'b1}};
   localparam logic [POS_W-1:0] BOT_POS = '0;
   localparam logic [POS_W-1:0] ONE     = POS_W'(1);

   logic at_top, at_bot;

   always_comb begin
      at_top = (cur_i == TOP_POS);
      at_bot = (cur_i == BOT_POS);
      if (up_i)
         nxt_o = at_top ? cur_i : cur_i + ONE;
      else
         nxt_o = at_bot ? cur_i : cur_i - ONE;
   end
endmodule

// File: rtl/wiper_load_arb.sv
module wiper_load_arb
   import wiper_pkg::*;
#(
   parameter int POS_W = 8
) (
   input  logic             recall_i,
   input  logic [POS_W-1:0] recall_val_i,
   input  logic             host_i,
   input  logic [POS_W-1:0] host_val_i,
   input  logic             copy_i,
   input  logic [POS_W-1:0] copy_val_i,
   input  logic             step_i,
   input  logic [POS_W-1:0] step_val_i,
   output logic             load_o,
   output logic [POS_W-1:0] val_o
);
   load_src_e sel;

   always_comb begin
      if (recall_i)      sel = SRC_RECALL;
      else if (host_i)   sel = SRC_HOST;
      else if (copy_i)   sel = SRC_COPY;
      else if (step_i)   sel = SRC_STEP;
      else               sel = SRC_NONE;
   end

   always_comb begin
      load_o = (sel != SRC_NONE);
      unique case (sel)
         SRC_RECALL: val_o = recall_val_i;
         SRC_HOST:   val_o = host_val_i;
         SRC_COPY:   val_o = copy_val_i;
         SRC_STEP:   val_o = step_val_i;
         default:    val_o = '0;
      endcase
   end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
   parameter int POS_W        = 8,
   parameter int DECODE_STYLE = 0,
   localparam int NUM_TAPS    = 1 << POS_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [POS_W-1:0]    pos_i,
   output logic [NUM_TAPS-1:0] tap_o
);
   localparam logic [NUM_TAPS-1:0] LOW_END = NUM_TAPS'(1);

   logic [NUM_TAPS-1:0] onehot_c;
   logic [NUM_TAPS-1:0] tap_q;

   generate
      if (DECODE_STYLE != 0 && DECODE_STYLE != 1) begin : g_bad_style
         $error("wiper_tap_decode: DECODE_STYLE must be 0 or 1");
      end
      if (DECODE_STYLE == 0) begin : g_cmp
         for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
            assign onehot_c[i] = (pos_i == POS_W'(i));
         end
      end else begin : g_shift
         assign onehot_c = LOW_END << pos_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q <= LOW_END;
      else        tap_q <= onehot_c;
   end

   assign tap_o = tap_q;

   // R10
   tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_q) == 1);

   // R10
   tap_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tap_q[$past(pos_i)] == 1'b1);
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg #(
   parameter int POS_W        = 8,
   parameter int DECODE_STYLE = 0,
   localparam int NUM_TAPS    = 1 << POS_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                recall_i,
   input  logic [POS_W-1:0]    recall_val_i,
   input  logic                host_wr_i,
   input  logic [POS_W-1:0]    host_val_i,
   input  logic                copy_wr_i,
   input  logic [POS_W-1:0]    copy_val_i,
   input  logic                step_mode_i,
   input  logic                step_pulse_i,
   input  logic                step_up_i,
   output logic [POS_W-1:0]    pos_o,
   output logic [NUM_TAPS-1:0] tap_o
);
   localparam logic [POS_W-1:0] TOP_POS = {POS_W{1'b1}};

   generate
      if (POS_W < 2 || POS_W > 10) begin : g_bad_width
         $error("wiper_pos_reg: POS_W must lie in 2..10");
      end
   endgenerate

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] step_val;
   logic [POS_W-1:0] load_val;
   logic             load_en;
   logic             step_req;

   assign step_req = step_mode_i & step_pulse_i;

   wiper_step_unit #(.POS_W(POS_W)) u_step (
      .cur_i (pos_q),
      .up_i  (step_up_i),
      .nxt_o (step_val)
   );

   wiper_load_arb #(.POS_W(POS_W)) u_arb (
      .recall_i     (recall_i),
      .recall_val_i (recall_val_i),
      .host_i       (host_wr_i),
      .host_val_i   (host_val_i),
      .copy_i       (copy_wr_i),
      .copy_val_i   (copy_val_i),
      .step_i       (step_req),
      .step_val_i   (step_val),
      .load_o       (load_en),
      .val_o        (load_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (load_en) pos_q <= load_val;
   end

   wiper_tap_decode #(.POS_W(POS_W), .DECODE_STYLE(DECODE_STYLE)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .pos_i (pos_q),
      .tap_o (tap_o)
   );

   assign pos_o = pos_q;

   // R2
   recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recall_i |=> pos_q == $past(recall_val_i));

   // R3
   host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_i && !recall_i) |=> pos_q == $past(host_val_i));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_i && !host_wr_i && !copy_wr_i && !(step_mode_i && step_pulse_i))
      |=> $stable(pos_q));

   // R8
   top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_i && !host_wr_i && !copy_wr_i && step_mode_i && step_pulse_i
       && step_up_i && pos_q == TOP_POS) |=> pos_q == TOP_POS);

   // R6
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_i && !host_wr_i && !copy_wr_i && step_mode_i && step_pulse_i
       && step_up_i && pos_q != TOP_POS) |=> pos_q == $past(pos_q) + POS_W'(1));
endmodule

// File: tb/wiper_pos_reg_bench.sv
module wiper_pos_reg_bench;
   localparam int POS_W = 8;
   localparam int NT    = 1 << POS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic recall = 0, host = 0, copy = 0, smode = 0, spulse = 0, sup = 0;
   logic [POS_W-1:0] rval = '0, hval = '0, cval = '0;
   logic [POS_W-1:0] pos;
   logic [NT-1:0]    tap;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wiper_pos_reg #(.POS_W(POS_W)) u_wiper_pos_reg (
      .clk(clk), .rst_n(rst_n),
      .recall_i(recall), .recall_val_i(rval),
      .host_wr_i(host), .host_val_i(hval),
      .copy_wr_i(copy), .copy_val_i(cval),
      .step_mode_i(smode), .step_pulse_i(spulse), .step_up_i(sup),
      .pos_o(pos), .tap_o(tap)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_tap(input string req, input int idx);
      logic [NT-1:0] e;
      e = NT'(1) << idx;
      n_chk++;
      if (tap !== e) begin
         n_fail++;
         $display("FAIL %s: actual tap %0h expected %0h", req, tap, e);
      end
   endtask

   // one clock cycle of strobes, starting and ending at a falling edge
   task automatic cyc(input logic r, input logic h, input logic c, input logic p,
                      input logic up);
      recall = r; host = h; copy = c; spulse = p; sup = up;
      @(negedge clk);
      recall = 0; host = 0; copy = 0; spulse = 0;
   endtask

   task automatic set_pos(input logic [POS_W-1:0] v);
      hval = v;
      cyc(0, 1, 0, 0, 0);
   endtask

   task automatic t_reset();
      chk("R1 reset position", pos, 0);
      chk_tap("R1 reset tap", 0);
   endtask

   task automatic t_recall();
      rval = 8'h5A;
      cyc(1, 0, 0, 0, 0);
      chk("R2 recall load", pos, 8'h5A);
      @(negedge clk);
      chk_tap("R10 tap after recall", 8'h5A);
   endtask

   task automatic t_host_copy();
      set_pos(8'h33);
      chk("R3 host load", pos, 8'h33);
      cval = 8'hC7;
      cyc(0, 0, 1, 0, 0);
      chk("R4 copy load", pos, 8'hC7);
   endtask

   task automatic t_priority();
      rval = 8'h11; hval = 8'h22; cval = 8'h33; smode = 1;
      cyc(1, 1, 1, 1, 1);
      chk("R5 recall beats all", pos, 8'h11);
      cyc(0, 1, 1, 1, 1);
      chk("R5 host beats copy/step", pos, 8'h22);
      cyc(0, 0, 1, 1, 1);
      chk("R5 copy beats step", pos, 8'h33);
      smode = 0;
   endtask

   task automatic t_step();
      set_pos(8'h10);
      smode = 1;
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1);
      chk("R6 three up steps", pos, 8'h13);
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0);
      chk("R7 five down steps", pos, 8'h0E);
      cyc(0, 0, 0, 0, 1);
      chk("R9 step mode without pulse holds", pos, 8'h0E);
      smode = 0;
   endtask

   task automatic t_sat();
      set_pos(8'hFF);
      smode = 1;
      cyc(0, 0, 0, 1, 1);
      chk("R8 up at top saturates", pos, 8'hFF);
      @(negedge clk);
      chk_tap("R10 top tap is high end", NT - 1);
      smode = 0;
      set_pos(8'h00);
      smode = 1;
      cyc(0, 0, 0, 1, 0);
      chk("R8 down at bottom saturates", pos, 8'h00);
      @(negedge clk);
      chk_tap("R10 zero tap is low end", 0);
      smode = 0;
   endtask

   task automatic t_ignore();
      set_pos(8'h80);
      smode = 0;
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, i[0]);
      chk("R9 pulses outside step mode ignored", pos, 8'h80);
      @(negedge clk);
      chk("R9 idle holds", pos, 8'h80);
   endtask

   task automatic t_tap_lag();
      set_pos(8'h40);
      @(negedge clk);
      set_pos(8'h41);
      chk("R10 position moved", pos, 8'h41);
      chk_tap("R10 tap lags one cycle", 8'h40);
      @(negedge clk);
      chk_tap("R10 tap catches up", 8'h41);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_recall();
      t_host_copy();
      t_priority();
      t_step();
      t_sat();
      t_ignore();
      t_tap_lag();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule